// File: doc/BRIEF.md
# Debug Suspend Routing Matrix

This block takes debug-halt requests from up to 32 processor cores and sends them to up to 64 peripheral sinks. Each sink has its own configuration word. The word picks how the sink's request is formed: it follows one chosen core, or it takes the AND or the OR of every core that is currently enabled. A 32-bit enable mask leaves absent or powered-down cores out of both reductions.

The routed request for each sink then passes through a qualifier before it becomes that peripheral's suspend output. A free-run bit makes the sink ignore debug halts altogether. A graceful-stop bit makes a new halt wait until the peripheral reports, on its own done input, that it has reached a safe completion point. Without that bit the halt takes effect at once. A write port loads the configuration words. A read port returns the word for any sink, together with a live bit that shows whether that sink is suspended.

Top module: `dsr_matrix`

## Requirements
- R1: After reset every sink word reads 0: mode AND (code 00), core index 0, free-run 0, graceful 0. Every suspend output is 0.
- R2: In mode 00 the routed request is 1 when at least one core is enabled and every enabled core requests. With an all-zero enable mask it is 0. Mode code 11 behaves exactly like mode 00.
- R3: In mode 01 the routed request is the OR of the requests of the enabled cores. With an all-zero enable mask it is 0.
- R4: In mode 10 the routed request follows the request of the core named by the index field, whatever the enable mask holds.
- R5: While a sink's free-run bit is 1, its suspend output is 0 on the following clock, whatever the requests are.
- R6: With graceful 0 and free-run 0, a suspend output goes to 1 on the clock after the routed request is seen high.
- R7: With graceful 1, a sink that is running and sees a routed request first goes to a pending state with its output still 0. It becomes suspended on the clock after the first cycle in which, while pending, its done input is high. It stays suspended while the request holds, whatever done does.
- R8: When the routed request is low, the sink returns to running and its output is 0 on the next clock. A later request starts again from running.
- R9: A write with wr_en high stores wr_data into the word of sink wr_addr. The word layout is mode in [1:0], core index in [6:2], free-run in [7] and graceful in [8]. rd_data returns the word of sink rd_addr in bits [8:0], with the live suspend status in bit [9].
- R10: If the graceful bit is cleared while a sink is pending and its request still holds, the sink becomes suspended one clock after the word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 32 | Halt request from each core |
| src_enable | input | 32 | Cores that take part in the AND and OR reductions |
| sink_done | input | 64 | Completion point reached, one bit per peripheral |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 6 | Sink selected for the write |
| wr_data | input | 9 | Configuration word to store |
| rd_addr | input | 6 | Sink selected for read-back |
| rd_data | output | 10 | Stored word plus live suspend status |
| sink_suspend | output | 64 | Registered suspend output, one bit per peripheral |

## Verification
The hardest case to reach is a graceful sink whose state changes while it is in the pending window. The three cases are: its done input rises in the same cycle as the request, the request drops before done arrives, and software clears the graceful bit in the middle of the wait. Directed sequences hold sink 40 in the pending state for several cycles and then trigger each of these events in turn. A long random phase then mixes writes to all sinks with sparse done pulses and enable masks that often have holes or are empty. A behavioural model compares every output bit and the read-back word on every clock.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [1:0] {
    MODE_AND = 2'd0,
    MODE_OR  = 2'd1,
    MODE_ONE = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PEND = 2'd1,
    ST_SUSP = 2'd2
  } state_e;

  // Qualifier transition: free-run and a dropped request both win over everything.
  function automatic state_e next_state(state_e cur, logic req, logic free_run,
                                        logic graceful, logic done);
    state_e nxt;
    if (free_run || !req) begin
      nxt = ST_RUN;
    end else if (!graceful) begin
      nxt = ST_SUSP;
    end else begin
      case (cur)
        ST_RUN:  nxt = ST_PEND;
        ST_PEND: nxt = done ? ST_SUSP : ST_PEND;
        default: nxt = ST_SUSP;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/dsr_cfg_regs.sv
module dsr_cfg_regs #(
  parameter int NUM_SINK = 64,
  parameter int IDX_W    = 5,
  localparam int ADDR_W  = $clog2(NUM_SINK),
  localparam int CFG_W   = IDX_W + 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [CFG_W-1:0]               wr_data,
  output logic [NUM_SINK-1:0][1:0]       mode_o,
  output logic [NUM_SINK-1:0][IDX_W-1:0] idx_o,
  output logic [NUM_SINK-1:0]            free_o,
  output logic [NUM_SINK-1:0]            soft_o
);

  logic [NUM_SINK-1:0][1:0]       mode_q;
  logic [NUM_SINK-1:0][IDX_W-1:0] idx_q;
  logic [NUM_SINK-1:0]            free_q;
  logic [NUM_SINK-1:0]            soft_q;

  for (genvar s = 0; s < NUM_SINK; s++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(s));
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[s] <= 2'b00;
        idx_q[s]  <= '0;
        free_q[s] <= 1'b0;
        soft_q[s] <= 1'b0;
      end else if (hit) begin
        mode_q[s] <= wr_data[1:0];
        idx_q[s]  <= wr_data[IDX_W+1:2];
        free_q[s] <= wr_data[IDX_W+2];
        soft_q[s] <= wr_data[IDX_W+3];
      end
    end
  end

  assign mode_o = mode_q;
  assign idx_o  = idx_q;
  assign free_o = free_q;
  assign soft_o = soft_q;

  // R9: the addressed word holds the written data on the next clock
  assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ({soft_q[$past(wr_addr)], free_q[$past(wr_addr)],
                idx_q[$past(wr_addr)], mode_q[$past(wr_addr)]} == $past(wr_data)));

  // R1: leaving reset, every word is zero
  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_q == '0 && free_q == '0 && soft_q == '0 && idx_q == '0));

endmodule

// File: rtl/dsr_reduce.sv
module dsr_reduce #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] src_enable,
  output logic               and_all,
  output logic               or_all
);

  logic any_enabled;

  assign any_enabled = |src_enable;
  assign and_all     = any_enabled && (&(src_req | ~src_enable));
  assign or_all      = |(src_req & src_enable);

  // R2 / R3: an empty mask yields no request from either reduction
  assert_empty_mask_R2: assert property (@(posedge clk) disable iff (rst)
    (src_enable == '0) |-> (!and_all && !or_all));

  // R3: all enabled requesting implies at least one enabled requesting
  assert_and_implies_or_R3: assert property (@(posedge clk) disable iff (rst)
    and_all |-> or_all);

endmodule

// File: rtl/dsr_select.sv
module dsr_select
  import dsr_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [1:0]         mode,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               and_all,
  input  logic               or_all,
  output logic               req
);

  always_comb begin
    case (mode_e'(mode))
      MODE_OR:  req = or_all;
      MODE_ONE: req = src_req[idx];
      default:  req = and_all;
    endcase
  end

endmodule

// File: rtl/dsr_qual.sv
module dsr_qual
  import dsr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req,
  input  logic   free_run,
  input  logic   graceful,
  input  logic   done,
  output logic   suspend,
  output state_e state_o
);

  state_e state_q;
  state_e state_d;

  assign state_d = next_state(state_q, req, free_run, graceful, done);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

  assign suspend = (state_q == ST_SUSP);
  assign state_o = state_q;

  assert_free_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    free_run |=> !suspend);

  assert_hard_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (req && !graceful && !free_run) |=> suspend);

  assert_soft_waits_R7: assert property (@(posedge clk) disable iff (rst)
    (req && graceful && !free_run && state_q == ST_RUN) |=> (!suspend && state_q == ST_PEND));

  assert_soft_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (req && graceful && !free_run && state_q == ST_SUSP) |=> suspend);

  assert_drop_runs_R8: assert property (@(posedge clk) disable iff (rst)
    !req |=> (state_q == ST_RUN));

  assert_soft_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PEND && req && !graceful && !free_run) |=> suspend);

endmodule

// File: rtl/dsr_matrix.sv
module dsr_matrix
  import dsr_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SINK = 64,
  localparam int IDX_W   = $clog2(NUM_SRC),
  localparam int ADDR_W  = $clog2(NUM_SINK),
  localparam int CFG_W   = IDX_W + 4,
  localparam int RD_W    = CFG_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  src_req,
  input  logic [NUM_SRC-1:0]  src_enable,
  input  logic [NUM_SINK-1:0] sink_done,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CFG_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [RD_W-1:0]     rd_data,
  output logic [NUM_SINK-1:0] sink_suspend
);

  logic [NUM_SINK-1:0][1:0]       cfg_mode;
  logic [NUM_SINK-1:0][IDX_W-1:0] cfg_idx;
  logic [NUM_SINK-1:0]            cfg_free;
  logic [NUM_SINK-1:0]            cfg_soft;
  logic                           red_and;
  logic                           red_or;
  logic [NUM_SINK-1:0]            routed_req;
  state_e                         sink_state [NUM_SINK];

  dsr_cfg_regs #(.NUM_SINK(NUM_SINK), .IDX_W(IDX_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode_o  (cfg_mode),
    .idx_o   (cfg_idx),
    .free_o  (cfg_free),
    .soft_o  (cfg_soft)
  );

  // One pair of reductions shared by every sink
  dsr_reduce #(.NUM_SRC(NUM_SRC)) u_reduce (
    .clk        (clk),
    .rst        (rst),
    .src_req    (src_req),
    .src_enable (src_enable),
    .and_all    (red_and),
    .or_all     (red_or)
  );

  for (genvar s = 0; s < NUM_SINK; s++) begin : g_sink
    dsr_select #(.NUM_SRC(NUM_SRC)) u_sel (
      .mode    (cfg_mode[s]),
      .idx     (cfg_idx[s]),
      .src_req (src_req),
      .and_all (red_and),
      .or_all  (red_or),
      .req     (routed_req[s])
    );

    dsr_qual u_qual (
      .clk      (clk),
      .rst      (rst),
      .req      (routed_req[s]),
      .free_run (cfg_free[s]),
      .graceful (cfg_soft[s]),
      .done     (sink_done[s]),
      .suspend  (sink_suspend[s]),
      .state_o  (sink_state[s])
    );
  end

  assign rd_data = {sink_suspend[rd_addr], cfg_soft[rd_addr], cfg_free[rd_addr],
                    cfg_idx[rd_addr], cfg_mode[rd_addr]};

  // R1: no sink is suspended in the first cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sink_suspend == '0));

  // R9: read-back status agrees with the addressed suspend output
  assert_status_matches_R9: assert property (@(posedge clk) disable iff (rst)
    rd_data[RD_W-1] == (sink_state[rd_addr] == ST_SUSP));

endmodule

// File: tb/dsr_matrix_tb.sv
`timescale 1ns/100ps
module dsr_matrix_tb_top;
  localparam int NSRC  = 32;
  localparam int NSINK = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_req = '0;
  logic [31:0] src_enable = '0;
  logic [63:0] sink_done = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [8:0]  wr_data = '0;
  logic [5:0]  rd_addr = '0;
  logic [9:0]  rd_data;
  logic [63:0] sink_suspend;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dsr_matrix dut_i (
    .clk(clk), .rst(rst), .src_req(src_req), .src_enable(src_enable),
    .sink_done(sink_done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sink_suspend(sink_suspend)
  );

  // Behavioural reference: 0 running, 1 pending, 2 suspended
  int m_mode [NSINK];
  int m_idx  [NSINK];
  int m_free [NSINK];
  int m_soft [NSINK];
  int m_st   [NSINK];

  function automatic bit model_req(int s);
    int n_en = 0;
    int n_hi = 0;
    if (m_mode[s] == 2) return src_req[m_idx[s]];
    for (int c = 0; c < NSRC; c++) begin
      if (src_enable[c]) begin
        n_en++;
        if (src_req[c]) n_hi++;
      end
    end
    if (m_mode[s] == 1) return n_hi > 0;
    return (n_en > 0) && (n_hi == n_en);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int s = 0; s < NSINK; s++) begin
        m_mode[s] = 0; m_idx[s] = 0; m_free[s] = 0; m_soft[s] = 0; m_st[s] = 0;
      end
    end else begin
      int nxt [NSINK];
      for (int s = 0; s < NSINK; s++) begin
        bit r;
        r = model_req(s);
        if (m_free[s] != 0 || !r)         nxt[s] = 0;
        else if (m_soft[s] == 0)          nxt[s] = 2;
        else if (m_st[s] == 2)            nxt[s] = 2;
        else if (m_st[s] == 1)            nxt[s] = sink_done[s] ? 2 : 1;
        else                              nxt[s] = 1;
      end
      for (int s = 0; s < NSINK; s++) m_st[s] = nxt[s];
      if (wr_en) begin
        m_mode[wr_addr] = int'(wr_data[1:0]);
        m_idx[wr_addr]  = int'(wr_data[6:2]);
        m_free[wr_addr] = int'(wr_data[7]);
        m_soft[wr_addr] = int'(wr_data[8]);
      end
    end
  end

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic compare_model();
    logic [63:0] e_vec;
    logic [9:0]  e_rd;
    for (int s = 0; s < NSINK; s++) e_vec[s] = (m_st[s] == 2);
    check("R2 R3 R4 R5 R6 R7 R8 R10 suspend vector vs model", sink_suspend, e_vec);
    e_rd = {e_vec[rd_addr], m_soft[rd_addr][0], m_free[rd_addr][0],
            m_idx[rd_addr][4:0], m_mode[rd_addr][1:0]};
    check("R9 readback vs model", {54'd0, rd_data}, {54'd0, e_rd});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  task automatic wr(int a, int mode, int idx, int fr, int sf);
    wr_en = 1'b1;
    wr_addr = 6'(a);
    wr_data = {1'(sf), 1'(fr), 5'(idx), 2'(mode)};
    tick();
    wr_en = 1'b0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    rd_addr = 6'd5;
    tick();
    check("R1 outputs zero after reset", sink_suspend, 64'd0);
    check("R1 readback zero after reset", {54'd0, rd_data}, 64'd0);

    // R2: default AND over all sinks
    src_enable = '1; src_req = '1; tick();
    check("R2 all requesting", sink_suspend, '1);
    src_req[3] = 1'b0; tick();
    check("R2 one enabled core low", sink_suspend, 64'd0);
    src_enable[3] = 1'b0; tick();
    check("R2 low core masked off", sink_suspend, '1);
    src_enable = '0; tick();
    check("R2 empty mask", sink_suspend, 64'd0);

    // R3: OR on sink 10
    src_req = '0; src_enable = '1;
    wr(10, 1, 0, 0, 0);
    src_req = 32'h0000_0080; tick();
    check("R3 OR single core", {62'd0, sink_suspend[11:10]}, 64'd1);
    src_enable = ~32'h0000_0080; tick();
    check("R3 OR core masked", {63'd0, sink_suspend[10]}, 64'd0);
    src_enable = '0; src_req = '1; tick();
    check("R3 OR empty mask", {63'd0, sink_suspend[10]}, 64'd0);

    // R4: single core on sink 20, reserved code on sink 21
    wr(20, 2, 9, 0, 0);
    src_req = 32'h0000_0200; tick();
    check("R4 single core ignores mask", {63'd0, sink_suspend[20]}, 64'd1);
    src_req = 32'h0000_0100; tick();
    check("R4 other core", {63'd0, sink_suspend[20]}, 64'd0);
    wr(21, 3, 0, 0, 0);
    src_enable = '1; src_req = '1; tick();
    check("R2 reserved code acts as AND high", {63'd0, sink_suspend[21]}, 64'd1);
    src_req = 32'hFFFF_FFFE; tick();
    check("R2 reserved code acts as AND low", {63'd0, sink_suspend[21]}, 64'd0);

    // R5 / R6
    wr(30, 0, 0, 1, 0);
    src_req = '1; tick();
    check("R5 free-run stays low, R6 neighbour rises", {62'd0, sink_suspend[31:30]}, 64'd2);
    src_req = '0; tick();
    check("R6 falls one clock after drop", {63'd0, sink_suspend[31]}, 64'd0);

    // R7 / R8 on sink 40
    wr(40, 0, 0, 0, 1);
    src_req = '1; tick();
    check("R7 pending after request", {63'd0, sink_suspend[40]}, 64'd0);
    tick();
    check("R7 still pending", {63'd0, sink_suspend[40]}, 64'd0);
    sink_done[40] = 1'b1; tick();
    check("R7 suspends after done", {63'd0, sink_suspend[40]}, 64'd1);
    sink_done[40] = 1'b0; tick();
    check("R7 holds without done", {63'd0, sink_suspend[40]}, 64'd1);
    src_req = '0; tick();
    check("R8 drop releases", {63'd0, sink_suspend[40]}, 64'd0);
    src_req = '1; sink_done[40] = 1'b1; tick();
    check("R7 done with request still pends", {63'd0, sink_suspend[40]}, 64'd0);
    tick();
    check("R7 then suspends", {63'd0, sink_suspend[40]}, 64'd1);
    src_req = '0; sink_done[40] = 1'b0; tick();
    src_req = '1; tick(); tick();
    src_req = '0; tick();
    check("R8 drop from pending", {63'd0, sink_suspend[40]}, 64'd0);
    src_req = '1; sink_done[40] = 1'b1; tick();
    check("R8 restarts from running", {63'd0, sink_suspend[40]}, 64'd0);
    sink_done[40] = 1'b0; src_req = '0; tick();

    // R10: clear graceful while pending
    src_req = '1; tick();
    wr(40, 0, 0, 0, 0);
    check("R10 write cycle still pending", {63'd0, sink_suspend[40]}, 64'd0);
    tick();
    check("R10 suspends after graceful cleared", {63'd0, sink_suspend[40]}, 64'd1);

    // R9 read-back
    wr(63, 1, 17, 1, 1);
    rd_addr = 6'd63; tick();
    check("R9 stored word", {54'd0, rd_data}, 64'd453);
    rd_addr = 6'd31; tick();
    check("R9 live status", {54'd0, rd_data}, 64'd512);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      src_req    = ~($urandom & $urandom & $urandom);
      src_enable = ($urandom_range(0, 7) == 0) ? '0 : ~($urandom & $urandom);
      for (int s = 0; s < NSINK; s++) sink_done[s] = ($urandom_range(0, 5) == 0);
      rd_addr = 6'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1'b1;
        wr_addr = 6'($urandom);
        wr_data = {1'($urandom), 1'($urandom_range(0, 7) == 0), 5'($urandom), 2'($urandom)};
      end else begin
        wr_en = 1'b0;
      end
      tick();
    end
    wr_en = 1'b0;
    report();
  end
endmodule